// File: doc/BRIEF.md
# Floating-Point Control and Status Register with Aliased Views

This block holds the 32-bit control and status word of a floating-point unit. Software reaches it through a small set of control register numbers. Most of these numbers are narrower windows onto the same word, so a field can be read or changed without a read-modify-write of the whole register. One number is a read-only implementation identifier. Every read value is sign-extended from bit 31 to the read bus width.

The arithmetic side of the unit reports the outcome of each operation through an update port. This port carries five exception status bits. The block replaces the per-operation cause field with them and accumulates them into sticky flags. After every write to a window that can change the causes or the enables, and after every update with a nonzero status, the block tests whether a trap is due. It raises a single-cycle trap request when one is.

Top module: `fpcsr_views`

## Requirements
- R1: After reset the status word is all zero and `trapReq` is low.
- R2: Register number 0 reads the `IMPL_ID` parameter. Writes to number 0, and writes to any number other than 25, 26, 28 and 31, change nothing. Reads of any number other than 0, 25, 26, 28 and 31 return zero.
- R3: Number 31 reads and writes the whole word. The word has this layout: rounding mode in bits 1:0, sticky flags in 6:2, enables in 11:7, causes in 17:12 with unimplemented at bit 17, condition code 0 at 23, flush-to-zero at 24, and condition codes 7..1 in 31:25. Bits 22:18 are always zero after a write and always read as zero.
- R4: Number 25 reads condition code 0 at bit 0 and condition codes 7..1 at bits 7:1. A write to number 25 takes bits 7:0 and places them back around the flush-to-zero bit. No other bit of the word changes.
- R5: Number 26 reads and writes only the cause bits 17:12 and the flag bits 6:2, both at their word positions.
- R6: Number 28 reads and writes the enables 11:7 and the rounding mode 1:0 at their word positions. It also carries flush-to-zero at bit 2, which maps to and from word bit 24.
- R7: The block tests for a trap after a write to number 26, 28 or 31. A trap is due if any of causes 16:12 has its matching enable bit set (bit 12 with bit 7, and so on), or if cause bit 17 is set whatever the enables hold. When a trap is due, `trapReq` goes high for exactly the one cycle after the triggering edge. A write to number 25 never raises it.
- R8: An update with status bit order [4] invalid, [3] divide-by-zero, [2] overflow, [1] underflow, [0] inexact has three effects. It loads causes 16:12 from the status and clears cause 17. It ORs the status into flags 6:2. It tests for a trap as in R7.
- R9: An update whose status is all zero clears every cause bit, leaves the flags unchanged and never raises a trap.
- R10: Every read value is bit 31 of the view, sign-extended to `XLEN` bits.
- R11: When a write and an update share a cycle, the update is applied first and the write is merged on top. The trap test uses the merged result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regSel | input | 5 | Control register number for read and write |
| wrEn | input | 1 | Write strobe for the selected number |
| wrData | input | 32 | Write value |
| rdData | output | XLEN | Sign-extended read value of the selected number |
| updEn | input | 1 | Per-operation status update strobe |
| updStatus | input | 5 | Exception status: invalid, divide-by-zero, overflow, underflow, inexact |
| trapReq | output | 1 | One-cycle trap request |

## Verification
Every field of the word can be seen through at least two views. A wrong stored bit therefore appears in the combinational read of the next cycle through both number 31 and the narrower window that owns the bit. A misplaced gap or a misplaced flush-to-zero bit shows up as a view value that disagrees with the full word. A trap decision made on the wrong value, such as the pre-write word or the causes before the update, appears on `trapReq` one cycle after the triggering edge. A stale or sticky trap request appears as a high level in the cycle after that.

// File: rtl/fpcsr_pkg.sv
package fpcsr_pkg;

  localparam int CSR_W    = 32;
  localparam int SEL_W    = 5;
  localparam int EXC_N    = 5;
  localparam int CAUSE_N  = EXC_N + 1;

  // field positions inside the status word
  localparam int RM_LO     = 0;
  localparam int RM_N      = 2;
  localparam int FLAG_LO   = 2;
  localparam int ENB_LO    = FLAG_LO + EXC_N;
  localparam int CAUSE_LO  = ENB_LO + EXC_N;
  localparam int UNIMP_BIT = CAUSE_LO + EXC_N;
  localparam int CC0_BIT   = 23;
  localparam int FTZ_BIT   = 24;
  localparam int CCHI_LO   = 25;
  localparam int CCHI_N    = CSR_W - CCHI_LO;
  localparam int CC_N      = CCHI_N + 1;
  localparam int ZERO_LO   = UNIMP_BIT + 1;
  localparam int ZERO_N    = CC0_BIT - ZERO_LO;
  localparam int FTZ_VIEW  = 2;

  localparam logic [CSR_W-1:0] ZERO_MASK  = ((CSR_W'(1) << ZERO_N) - 1) << ZERO_LO;
  localparam logic [CSR_W-1:0] EXC_MASK   = (((CSR_W'(1) << CAUSE_N) - 1) << CAUSE_LO)
                                          | (((CSR_W'(1) << EXC_N) - 1) << FLAG_LO);
  localparam logic [CSR_W-1:0] ENB_MASK   = (((CSR_W'(1) << EXC_N) - 1) << ENB_LO)
                                          | (((CSR_W'(1) << RM_N) - 1) << RM_LO);

  // control register numbers
  localparam logic [SEL_W-1:0] SEL_IMPL = 5'd0;
  localparam logic [SEL_W-1:0] SEL_CC   = 5'd25;
  localparam logic [SEL_W-1:0] SEL_EXC  = 5'd26;
  localparam logic [SEL_W-1:0] SEL_ENB  = 5'd28;
  localparam logic [SEL_W-1:0] SEL_FULL = 5'd31;

  typedef enum logic [2:0] {
    VIEW_NONE, VIEW_IMPL, VIEW_CC, VIEW_EXC, VIEW_ENB, VIEW_FULL
  } view_e;

  typedef struct packed {
    logic  wrCc;
    logic  wrExc;
    logic  wrEnb;
    logic  wrFull;
    logic  updEv;
    logic  updTest;
    view_e rdView;
  } strobe_t;

endpackage

// File: rtl/fpcsr_ctrl.sv
module fpcsr_ctrl
  import fpcsr_pkg::*;
(
  input  logic [SEL_W-1:0] regSel,
  input  logic             wrEn,
  input  logic             updEn,
  input  logic [EXC_N-1:0] updStatus,
  output strobe_t          stb
);

  always_comb begin
    stb        = '0;
    stb.rdView = VIEW_NONE;
    case (regSel)
      SEL_IMPL: stb.rdView = VIEW_IMPL;
      SEL_CC: begin
        stb.rdView = VIEW_CC;
        stb.wrCc   = wrEn;
      end
      SEL_EXC: begin
        stb.rdView = VIEW_EXC;
        stb.wrExc  = wrEn;
      end
      SEL_ENB: begin
        stb.rdView = VIEW_ENB;
        stb.wrEnb  = wrEn;
      end
      SEL_FULL: begin
        stb.rdView = VIEW_FULL;
        stb.wrFull = wrEn;
      end
      default: ;
    endcase
    stb.updEv   = updEn;
    // an all-zero status clears causes but does not test for a trap (R9)
    stb.updTest = updEn && (|updStatus);
  end

endmodule

// File: rtl/fpcsr_dp.sv
module fpcsr_dp
  import fpcsr_pkg::*;
#(
  parameter int                XLEN    = 64,
  parameter logic [CSR_W-1:0]  IMPL_ID = 32'h8003_0100
)(
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic [CSR_W-1:0] wrWord,
  input  logic [EXC_N-1:0] updStatus,
  output logic [XLEN-1:0]  rdData,
  output logic             trapReq
);

  logic [CSR_W-1:0] csrQ;
  logic [CSR_W-1:0] afterUpd;
  logic [CSR_W-1:0] csrD;
  logic [CSR_W-1:0] viewWord;
  logic             trapTest;
  logic             trapD;

  // update first (R8, R9), then the write on top (R11)
  always_comb begin
    afterUpd = csrQ;
    if (stb.updEv) begin
      afterUpd[CAUSE_LO +: CAUSE_N] = {1'b0, updStatus};
      afterUpd[FLAG_LO +: EXC_N]    = csrQ[FLAG_LO +: EXC_N] | updStatus;
    end
  end

  always_comb begin
    csrD = afterUpd;
    if (stb.wrCc) begin
      csrD[CC0_BIT]              = wrWord[0];
      csrD[CCHI_LO +: CCHI_N]    = wrWord[1 +: CCHI_N];
    end
    if (stb.wrExc) begin
      csrD[CAUSE_LO +: CAUSE_N]  = wrWord[CAUSE_LO +: CAUSE_N];
      csrD[FLAG_LO +: EXC_N]     = wrWord[FLAG_LO +: EXC_N];
    end
    if (stb.wrEnb) begin
      csrD[ENB_LO +: EXC_N]      = wrWord[ENB_LO +: EXC_N];
      csrD[RM_LO +: RM_N]        = wrWord[RM_LO +: RM_N];
      csrD[FTZ_BIT]              = wrWord[FTZ_VIEW];
    end
    if (stb.wrFull) begin
      csrD = wrWord & ~ZERO_MASK;
    end
  end

  assign trapTest = stb.wrExc | stb.wrEnb | stb.wrFull | stb.updTest;
  assign trapD    = trapTest &&
                    ((|(csrD[CAUSE_LO +: EXC_N] & csrD[ENB_LO +: EXC_N])) || csrD[UNIMP_BIT]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      csrQ    <= '0;
      trapReq <= 1'b0;
    end else begin
      csrQ    <= csrD;
      trapReq <= trapD;
    end
  end

  // view formatting
  always_comb begin
    viewWord = '0;
    case (stb.rdView)
      VIEW_IMPL: viewWord = IMPL_ID;
      VIEW_CC:   viewWord = CSR_W'({csrQ[CCHI_LO +: CCHI_N], csrQ[CC0_BIT]});
      VIEW_EXC:  viewWord = csrQ & EXC_MASK;
      VIEW_ENB: begin
        viewWord           = csrQ & ENB_MASK;
        viewWord[FTZ_VIEW] = csrQ[FTZ_BIT];
      end
      VIEW_FULL: viewWord = csrQ & ~ZERO_MASK;
      default:   viewWord = '0;
    endcase
  end

  // R10 sign extension to the read bus
  generate
    if (XLEN > CSR_W) begin : g_ext
      assign rdData = {{(XLEN-CSR_W){viewWord[CSR_W-1]}}, viewWord};
    end else begin : g_flat
      assign rdData = viewWord;
    end
  endgenerate

  // R3
  full_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrFull |=> csrQ == ($past(wrWord) & ~ZERO_MASK));

  // R7
  trap_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    trapReq |-> $past(stb.wrExc | stb.wrEnb | stb.wrFull | stb.updTest));

  // R8
  upd_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.updEv && !stb.wrExc && !stb.wrFull)
      |=> csrQ[CAUSE_LO +: CAUSE_N] == {1'b0, $past(updStatus)});

  // R8
  sticky_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.updEv && !stb.wrExc && !stb.wrFull)
      |=> (csrQ[FLAG_LO +: EXC_N] & $past(csrQ[FLAG_LO +: EXC_N])) == $past(csrQ[FLAG_LO +: EXC_N]));

  // R4
  cc_isolate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrCc && !stb.updEv)
      |=> (csrQ[CC0_BIT-1:0] == $past(csrQ[CC0_BIT-1:0])) && (csrQ[FTZ_BIT] == $past(csrQ[FTZ_BIT])));

endmodule

// File: rtl/fpcsr_views.sv
module fpcsr_views
  import fpcsr_pkg::*;
#(
  parameter int               XLEN    = 64,
  parameter logic [CSR_W-1:0] IMPL_ID = 32'h8003_0100
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic [SEL_W-1:0] regSel,
  input  logic             wrEn,
  input  logic [CSR_W-1:0] wrData,
  output logic [XLEN-1:0]  rdData,
  input  logic             updEn,
  input  logic [EXC_N-1:0] updStatus,
  output logic             trapReq
);

  strobe_t stb;

  fpcsr_ctrl u_ctrl (
    .regSel    (regSel),
    .wrEn      (wrEn),
    .updEn     (updEn),
    .updStatus (updStatus),
    .stb       (stb)
  );

  fpcsr_dp #(.XLEN(XLEN), .IMPL_ID(IMPL_ID)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .wrWord    (wrData),
    .updStatus (updStatus),
    .rdData    (rdData),
    .trapReq   (trapReq)
  );

endmodule

// File: tb/fpcsr_views_bench.sv
module fpcsr_views_bench;

  logic        clk = 1'b0;
  logic        rstN;
  logic [4:0]  regSel;
  logic        wrEn;
  logic [31:0] wrData;
  logic [63:0] rdData;
  logic        updEn;
  logic [4:0]  updStatus;
  logic        trapReq;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  always #10 clk = ~clk;

  fpcsr_views u_fpcsr_views (
    .clk(clk), .rstN(rstN), .regSel(regSel), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .updEn(updEn), .updStatus(updStatus), .trapReq(trapReq)
  );

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // one edge with the given access; returns trapReq seen after that edge
  task automatic step(input logic [4:0] sel, input logic wr, input logic [31:0] d,
                      input logic upd, input logic [4:0] st, output logic trap);
    @(negedge clk);
    regSel = sel; wrEn = wr; wrData = d; updEn = upd; updStatus = st;
    @(negedge clk);
    trap = trapReq;
    wrEn = 1'b0; updEn = 1'b0; updStatus = '0;
  endtask

  task automatic readView(input logic [4:0] sel, output logic [63:0] v);
    @(negedge clk);
    regSel = sel;
    #1 v = rdData;
  endtask

  task automatic testReset();
    logic [63:0] v;
    check("R1 trap after reset", {63'b0, trapReq}, 64'd0);
    readView(5'd31, v); check("R1 word after reset", v, 64'd0);
    readView(5'd0, v);  check("R2/R10 implementation id", v, 64'hFFFF_FFFF_8003_0100);
  endtask

  task automatic testFullView();
    logic t; logic [63:0] v;
    step(5'd31, 1, 32'hFFFF_FFFF, 0, 0, t); check("R7 full write trap", {63'b0, t}, 64'd1);
    readView(5'd31, v); check("R3/R10 full read zero bits", v, 64'hFFFF_FFFF_FF83_FFFF);
    readView(5'd25, v); check("R4 packed cc read", v, 64'h0000_00FF);
    readView(5'd28, v); check("R6 enables view read", v, 64'h0000_0F87);
    readView(5'd26, v); check("R5 exception view read", v, 64'h0003_F07C);
  endtask

  task automatic testCcView();
    logic t; logic [63:0] v;
    step(5'd25, 1, 32'h0000_0000, 0, 0, t); check("R7 cc write no trap", {63'b0, t}, 64'd0);
    readView(5'd31, v); check("R4 cc write keeps others", v, 64'h0000_0000_0103_FFFF);
    step(5'd31, 1, 32'h0, 0, 0, t);
    step(5'd25, 1, 32'h0000_005A, 0, 0, t);
    readView(5'd31, v); check("R4 cc expand", v, 64'h5A00_0000);
    readView(5'd25, v); check("R4 cc packed readback", v, 64'h5A);
    step(5'd25, 1, 32'hFFFF_FF01, 0, 0, t);
    readView(5'd31, v); check("R4 cc bit0 placement", v, 64'h0080_0000);
    readView(5'd25, v); check("R4 cc bit0 readback", v, 64'h01);
  endtask

  task automatic testEnbView();
    logic t; logic [63:0] v;
    step(5'd28, 1, 32'h0000_0F85, 0, 0, t); check("R7 enables no cause no trap", {63'b0, t}, 64'd0);
    readView(5'd31, v); check("R6 flush bit relocated", v, 64'h0180_0F81);
    readView(5'd28, v); check("R6 enables readback", v, 64'h0F85);
    step(5'd28, 1, 32'h0, 0, 0, t);
    readView(5'd31, v); check("R6 flush cleared", v, 64'h0080_0000);
  endtask

  task automatic testExcView();
    logic t; logic [63:0] v;
    step(5'd26, 1, 32'hFFFF_FFFF, 0, 0, t); check("R7 unimplemented traps", {63'b0, t}, 64'd1);
    @(negedge clk); check("R7 one-cycle pulse", {63'b0, trapReq}, 64'd0);
    readView(5'd31, v); check("R5 only cause and flags", v, 64'h0083_F07C);
    step(5'd26, 1, 32'h0001_0000, 0, 0, t); check("R7 cause without enable", {63'b0, t}, 64'd0);
    readView(5'd26, v); check("R5 exc readback", v, 64'h0001_0000);
    step(5'd28, 1, 32'h0000_0800, 0, 0, t); check("R7 matched enable", {63'b0, t}, 64'd1);
    step(5'd28, 1, 32'h0000_0400, 0, 0, t); check("R7 unmatched enable", {63'b0, t}, 64'd0);
  endtask

  task automatic testUpdate();
    logic t; logic [63:0] v;
    step(5'd31, 0, 0, 1, 5'b01000, t); check("R8 divzero trap", {63'b0, t}, 64'd1);
    readView(5'd26, v); check("R8 cause replaced, flag set", v, 64'h8020);
    step(5'd31, 0, 0, 1, 5'b00001, t); check("R8 inexact no trap", {63'b0, t}, 64'd0);
    readView(5'd26, v); check("R8 flags accumulate", v, 64'h1024);
    step(5'd31, 0, 0, 1, 5'b00000, t); check("R9 zero status no trap", {63'b0, t}, 64'd0);
    readView(5'd26, v); check("R9 causes cleared flags kept", v, 64'h0024);
    step(5'd26, 1, 32'h0002_0000, 0, 0, t); check("R7 unimplemented via view", {63'b0, t}, 64'd1);
    step(5'd31, 0, 0, 1, 5'b00010, t); check("R8 unimplemented cleared", {63'b0, t}, 64'd0);
    readView(5'd26, v); check("R8 unimplemented not sticky", v, 64'h2008);
    readView(5'd31, v); check("R8 word after update", v, 64'h0080_2408);
  endtask

  task automatic testIgnored();
    logic t; logic [63:0] v;
    step(5'd5, 1, 32'hFFFF_FFFF, 0, 0, t); check("R2 unlisted write no trap", {63'b0, t}, 64'd0);
    step(5'd0, 1, 32'hFFFF_FFFF, 0, 0, t); check("R2 id write no trap", {63'b0, t}, 64'd0);
    readView(5'd31, v); check("R2 writes ignored", v, 64'h0080_2408);
    readView(5'd5, v);  check("R2 unlisted read zero", v, 64'd0);
    readView(5'd0, v);  check("R2 id unchanged", v, 64'hFFFF_FFFF_8003_0100);
  endtask

  task automatic testCollision();
    logic t; logic [63:0] v;
    step(5'd31, 1, 32'h0, 0, 0, t);
    step(5'd28, 1, 32'h0000_0800, 1, 5'b10000, t); check("R11 merged trap", {63'b0, t}, 64'd1);
    readView(5'd31, v); check("R11 update then write", v, 64'h0001_0840);
  endtask

  initial begin
    rstN = 1'b0; regSel = '0; wrEn = 0; wrData = '0; updEn = 0; updStatus = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testFullView();
    testCcView();
    testEnbView();
    testExcView();
    testUpdate();
    testIgnored();
    testCollision();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      nChecks++; nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule